// File: doc/BRIEF.md
# Multiplexed 5x7 Character Display Core

This block holds one character for a single-position 5x7 dot-matrix display and turns it into the strobes that light the matrix. A host writes a 7-bit character code through a port that behaves like a small RAM: it presents the code, pulls chip enable low and pulses write low. These strobes are not tied to the block's clock. The block brings the combined strobe into its clock domain and stores the code when the strobe is released. The stored code stays in place until a later write replaces it.

A synchronous scanner drives the five columns in turn. It places one column on the row lines at a time, so twelve lines serve all thirty-five dots. Each column slot is split into brightness sub-slots. A two-bit level input sets how many of those sub-slots light, or darkens the display completely. An active-low lamp-test input lights every dot at the lowest lit level. It overrides the level input and does not touch the stored code. A host can blink the display by toggling the level input, or use lamp test as a cursor, and the stored character is not lost in either case.

Top module: `char_display_core`

## Requirements
- R1: After reset the stored code is 0x20 (space), so every column strobe may fire but every row line stays low.
- R2: A code is accepted only while `ce_n` and `wr_n` are both low, and it is stored after that combined strobe is released. A write pulse with `ce_n` high leaves the shown character unchanged, and a stored code stays until the next accepted write.
- R3: The stored value is the value `din` holds while the strobe is low. Bit 0 is the least significant bit and bit 6 the most significant.
- R4: Column strobes are one-hot or zero. Bit c of `col_en` selects column c, with column 0 on the left. Columns are scanned in the order 0,1,2,3,4 and then wrap, and each column owns 14 consecutive clock cycles, so a frame lasts 70 cycles.
- R5: During a lit sub-slot, bit r of `row_en` is the dot in row r (row 0 at the top) of the current column of the stored glyph. Code 0x41 gives the column patterns 0x7E,0x11,0x11,0x11,0x7E, and code 0x31 gives 0x00,0x42,0x7F,0x40,0x00.
- R6: `blank_lvl` sets how many of the 14 sub-slots of each column are lit, counting from the first sub-slot: 2'b00 lights 0, 2'b01 lights 2, 2'b10 lights 7 and 2'b11 lights 14.
- R7: In an unlit sub-slot both `col_en` and `row_en` are all zero.
- R8: While `lamp_test_n` is low, every column shows row pattern 0x7F for 2 of its 14 sub-slots whatever the value of `blank_lvl`. When it is released, the stored character returns.
- R9: Changing `blank_lvl` never changes the stored code.
- R10: Codes outside the digits 0x30-0x39 and the capitals 0x41-0x5A (the space 0x20 included) give all-off row patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Active-low chip enable, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| din | input | 7 | Character code |
| blank_lvl | input | 2 | Brightness level: 00 dark, 01 low, 10 half, 11 full |
| lamp_test_n | input | 1 | Active-low lamp test |
| col_en | output | 5 | Column strobes, one-hot or zero |
| row_en | output | 7 | Row drives for the selected column |

## Verification
Every cycle, the assertions check the following. Column strobes are one-hot or zero, rows are never driven without a column, and lamp test drives all rows with every strobe. The dark level keeps every strobe off. The stored code changes only on a commit event, and the column index steps to the next column at the end of each slot. Only the bench's frame-long scenarios can show the rest. These are the per-column lit counts for each level, the glyph patterns of specific codes, writes that are ignored when chip enable is high, and the character surviving blanking and lamp test.

// File: rtl/dispc_pkg.sv
package dispc_pkg;
  localparam int CODE_W = 7;
  localparam int N_COLS = 5;
  localparam int N_ROWS = 7;
  localparam logic [CODE_W-1:0] RESET_CODE = 7'h20;

  // number of lit sub-slots out of subs for a level code
  function automatic int lit_slots(input logic [1:0] lvl, input int subs);
    case (lvl)
      2'b00:   return 0;
      2'b01:   return subs / 7;
      2'b10:   return subs / 2;
      default: return subs;
    endcase
  endfunction

  // glyph as five column bytes, column 0 in the low byte, row 0 in bit 0
  function automatic logic [39:0] glyph_cols(input logic [CODE_W-1:0] code);
    case (code)
      7'h30: return 40'h3E_45_49_51_3E;
      7'h31: return 40'h00_40_7F_42_00;
      7'h32: return 40'h46_49_51_61_42;
      7'h33: return 40'h31_4B_45_41_21;
      7'h34: return 40'h10_7F_12_14_18;
      7'h35: return 40'h39_45_45_45_27;
      7'h36: return 40'h30_49_49_4A_3C;
      7'h37: return 40'h03_05_09_71_01;
      7'h38: return 40'h36_49_49_49_36;
      7'h39: return 40'h1E_29_49_49_06;
      7'h41: return 40'h7E_11_11_11_7E;
      7'h42: return 40'h36_49_49_49_7F;
      7'h43: return 40'h22_41_41_41_3E;
      7'h44: return 40'h1C_22_41_41_7F;
      7'h45: return 40'h41_49_49_49_7F;
      7'h46: return 40'h01_01_09_09_7F;
      7'h47: return 40'h32_51_41_41_3E;
      7'h48: return 40'h7F_08_08_08_7F;
      7'h49: return 40'h00_41_7F_41_00;
      7'h4A: return 40'h01_3F_41_40_20;
      7'h4B: return 40'h41_22_14_08_7F;
      7'h4C: return 40'h40_40_40_40_7F;
      7'h4D: return 40'h7F_02_04_02_7F;
      7'h4E: return 40'h7F_10_08_04_7F;
      7'h4F: return 40'h3E_41_41_41_3E;
      7'h50: return 40'h06_09_09_09_7F;
      7'h51: return 40'h5E_21_51_41_3E;
      7'h52: return 40'h46_29_19_09_7F;
      7'h53: return 40'h31_49_49_49_46;
      7'h54: return 40'h01_01_7F_01_01;
      7'h55: return 40'h3F_40_40_40_3F;
      7'h56: return 40'h1F_20_40_20_1F;
      7'h57: return 40'h7F_20_18_20_7F;
      7'h58: return 40'h63_14_08_14_63;
      7'h59: return 40'h03_04_78_04_03;
      7'h5A: return 40'h43_45_49_51_61;
      default: return 40'h0;
    endcase
  endfunction
endpackage

// File: rtl/dispc_wr_sync.sv
module dispc_wr_sync #(
  parameter int STAGES = 2,
  parameter int CODE_W = 7,
  parameter logic [CODE_W-1:0] INIT_CODE = 7'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              wr_n,
  input  logic [CODE_W-1:0] din,
  output logic              commit,
  output logic [CODE_W-1:0] code
);
  logic              stb_raw;
  logic [STAGES-1:0] sync_q;
  logic              stb_s;
  logic              stb_prev;
  logic [CODE_W-1:0] hold_q;

  assign stb_raw = ~(ce_n | wr_n);

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sync_q[i] <= 1'b0;
      else if (i == 0) sync_q[i] <= stb_raw;
      else             sync_q[i] <= sync_q[i-1];
    end
  end

  assign stb_s  = sync_q[STAGES-1];
  assign commit = stb_prev & ~stb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev <= 1'b0;
      hold_q   <= INIT_CODE;
      code     <= INIT_CODE;
    end else begin
      stb_prev <= stb_s;
      if (stb_s)  hold_q <= din;
      if (commit) code   <= hold_q;
    end
  end
endmodule

// File: rtl/dispc_scan.sv
module dispc_scan #(
  parameter int COLS = 5,
  parameter int SUBS = 14,
  localparam int CW = $clog2(COLS),
  localparam int SW = $clog2(SUBS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] col,
  output logic [SW-1:0] sub
);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      sub <= '0;
    end else if (sub == SUB_LAST) begin
      sub <= '0;
      col <= (col == COL_LAST) ? '0 : col + 1'b1;
    end else begin
      sub <= sub + 1'b1;
    end
  end
endmodule

// File: rtl/dispc_font.sv
module dispc_font
  import dispc_pkg::*;
#(
  parameter int COLS = 5,
  localparam int CW = $clog2(COLS)
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CW-1:0]     col,
  output logic [N_ROWS-1:0] rows
);
  logic [39:0] cols_all;
  always_comb begin
    cols_all = glyph_cols(code);
    rows     = cols_all[{col, 3'b000} +: N_ROWS];
  end
endmodule

// File: rtl/char_display_core.sv
module char_display_core
  import dispc_pkg::*;
#(
  parameter int SUB_SLOTS   = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              wr_n,
  input  logic [CODE_W-1:0] din,
  input  logic [1:0]        blank_lvl,
  input  logic              lamp_test_n,
  output logic [N_COLS-1:0] col_en,
  output logic [N_ROWS-1:0] row_en
);
  localparam int CW = $clog2(N_COLS);
  localparam int SW = $clog2(SUB_SLOTS);

  logic              wr_commit;
  logic [CODE_W-1:0] code_q;
  logic [CW-1:0]     scan_col;
  logic [SW-1:0]     scan_sub;
  logic [N_ROWS-1:0] glyph_rows;
  logic [N_ROWS-1:0] shown_rows;
  logic              slot_on;
  int                duty;

  dispc_wr_sync #(.STAGES(SYNC_STAGES), .CODE_W(CODE_W), .INIT_CODE(RESET_CODE)) u_wr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .din(din),
    .commit(wr_commit), .code(code_q)
  );

  dispc_scan #(.COLS(N_COLS), .SUBS(SUB_SLOTS)) u_scan (
    .clk(clk), .rst_n(rst_n), .col(scan_col), .sub(scan_sub)
  );

  dispc_font #(.COLS(N_COLS)) u_font (
    .code(code_q), .col(scan_col), .rows(glyph_rows)
  );

  always_comb begin
    duty       = lamp_test_n ? lit_slots(blank_lvl, SUB_SLOTS) : lit_slots(2'b01, SUB_SLOTS);
    shown_rows = lamp_test_n ? glyph_rows : '1;
    slot_on    = int'(scan_sub) < duty;
    col_en     = slot_on ? (N_COLS'(1) << scan_col) : '0;
    row_en     = slot_on ? shown_rows : '0;
  end
endmodule

// File: rtl/char_display_core_chk.sv
module char_display_core_chk #(
  parameter int COLS = 5,
  parameter int ROWS = 7,
  parameter int SUBS = 14,
  parameter int CW = 3,
  parameter int SW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [COLS-1:0] col_en,
  input logic [ROWS-1:0] row_en,
  input logic [1:0]      blank_lvl,
  input logic            lamp_test_n,
  input logic            wr_commit,
  input logic [6:0]      code_q,
  input logic [CW-1:0]   scan_col,
  input logic [SW-1:0]   scan_sub
);
  // R4
  col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_en));
  // R7
  rows_need_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_en == '0) |-> (row_en == '0));
  // R8
  lamp_full_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp_test_n && col_en != '0) |-> (row_en == '1));
  // R6
  dark_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n && blank_lvl == 2'b00) |-> (col_en == '0));
  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(code_q));
  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(scan_sub) == SUBS - 1) |=>
      (int'(scan_col) == ((int'($past(scan_col)) == COLS - 1) ? 0 : int'($past(scan_col)) + 1)));
endmodule

bind char_display_core char_display_core_chk #(
  .COLS(5), .ROWS(7), .SUBS(SUB_SLOTS), .CW(CW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .col_en(col_en), .row_en(row_en),
  .blank_lvl(blank_lvl), .lamp_test_n(lamp_test_n), .wr_commit(wr_commit),
  .code_q(code_q), .scan_col(scan_col), .scan_sub(scan_sub)
);

// File: tb/tb_char_display_core.sv
module tb_char_display_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [6:0] din = 7'h00;
  logic [1:0] blank_lvl = 2'b11;
  logic       lamp_test_n = 1'b1;
  logic [4:0] col_en;
  logic [6:0] row_en;

  int total = 0;
  int bad = 0;
  bit mon_busy = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [4:0][6:0] rows;
    int              duty;
    string           tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  char_display_core dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .din(din),
    .blank_lvl(blank_lvl), .lamp_test_n(lamp_test_n),
    .col_en(col_en), .row_en(row_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_frame(input logic [4:0][6:0] rows, input int duty, input string tag);
    exp_t e;
    e.rows = rows; e.duty = duty; e.tag = tag;
    repeat (3) @(negedge clk);
    q.push_back(e);
    #1;
    wait (q.size() == 0 && !mon_busy);
  endtask

  task automatic host_write(input logic [6:0] v, input bit chip_sel);
    @(negedge clk);
    din = v; ce_n = !chip_sel;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    ce_n = 1'b1; din = 7'h55;
    repeat (4) @(negedge clk);
  endtask

  // monitor: one 70-cycle window per expected item
  initial begin
    forever begin
      exp_t e;
      int cnt [5];
      bit row_ok [5];
      int bad_row [5];
      bit order_ok;
      int prev_c;
      wait (q.size() > 0);
      mon_busy = 1'b1;
      e = q.pop_front();
      for (int c = 0; c < 5; c++) begin cnt[c] = 0; row_ok[c] = 1'b1; bad_row[c] = 0; end
      order_ok = 1'b1;
      prev_c = -1;
      for (int t = 0; t < 70; t++) begin
        @(negedge clk);
        if (col_en != 5'b0) begin
          int c;
          c = $clog2(col_en);
          if ((col_en & (col_en - 5'd1)) != 5'b0) order_ok = 1'b0;
          if (prev_c >= 0 && c != prev_c && c != (prev_c + 1) % 5) order_ok = 1'b0;
          prev_c = c;
          cnt[c]++;
          if (row_en != e.rows[c]) begin row_ok[c] = 1'b0; bad_row[c] = row_en; end
        end else if (row_en != 7'b0) begin
          order_ok = 1'b0;
        end
      end
      check(order_ok, {e.tag, " R4 R7 scan order/dark slots"}, 0, 0);
      for (int c = 0; c < 5; c++) begin
        check(cnt[c] == e.duty, {e.tag, " R6 lit count"}, cnt[c], e.duty);
        if (e.duty > 0)
          check(row_ok[c], {e.tag, " R5 rows"}, bad_row[c], e.rows[c]);
      end
      mon_busy = 1'b0;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [4:0][6:0] G_BLANK = '0;
  localparam logic [4:0][6:0] G_A     = {7'h7E, 7'h11, 7'h11, 7'h11, 7'h7E};
  localparam logic [4:0][6:0] G_ONE   = {7'h00, 7'h40, 7'h7F, 7'h42, 7'h00};
  localparam logic [4:0][6:0] G_ALL   = {5{7'h7F}};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_frame(G_BLANK, 14, "R1 reset space");
    host_write(7'h41, 1'b1);
    expect_frame(G_A, 14, "R2 R3 R5 write A");
    blank_lvl = 2'b01; expect_frame(G_A, 2, "R6 level 01");
    blank_lvl = 2'b10; expect_frame(G_A, 7, "R6 level 10");
    blank_lvl = 2'b00; expect_frame(G_A, 0, "R6 R7 dark");
    blank_lvl = 2'b11; expect_frame(G_A, 14, "R9 code kept after blanking");
    host_write(7'h31, 1'b0);
    expect_frame(G_A, 14, "R2 write ignored without chip enable");
    host_write(7'h31, 1'b1);
    expect_frame(G_ONE, 14, "R3 R5 write 1");
    blank_lvl = 2'b00; lamp_test_n = 1'b0;
    expect_frame(G_ALL, 2, "R8 lamp test over dark");
    blank_lvl = 2'b11;
    expect_frame(G_ALL, 2, "R8 lamp test over full");
    lamp_test_n = 1'b1;
    expect_frame(G_ONE, 14, "R8 character back after lamp test");
    host_write(7'h61, 1'b1);
    expect_frame(G_BLANK, 14, "R10 lowercase off");
    host_write(7'h7F, 1'b1);
    expect_frame(G_BLANK, 14, "R10 code 7F off");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule